// File: doc/BRIEF.md
# Parallel Prefix Carry Adder

This block is an n-bit binary adder whose carries come from a parallel prefix network. The network shape is chosen at elaboration time. Three trees are available: Kogge-Stone, Sklansky and Brent-Kung. Each can be built from two-input combine nodes (radix 2) or four-input combine nodes (radix 4). A radix-4 node joins up to four adjacent bit groups in one level. This cuts the number of levels, but each node is larger.

A thin front end forms a generate bit (a AND b) and a propagate bit (a XOR b) for each position. The prefix network turns these into a group generate and a group propagate over each span from bit i down to bit 0. The carry into bit i+1 is the group generate OR (the group propagate AND the carry-in). Each sum bit is its propagate XOR the carry into that bit.

Sum, carry-out and the full carry vector are registered on the rising clock edge. Results therefore appear one cycle after the operands are applied.

Top module: `prefix_carry_adder`

## Requirements
- R1: One clock edge after operands a, b and cin are sampled with rst low, {cout, sum} equals a + b + cin taken as an unsigned WIDTH+1-bit value.
- R2: One edge after sampling, bit i of `carry` is the carry into sum bit i. Bit 0 equals the sampled cin, and bit i above 0 is the carry out of bit i-1, so `carry` equals a XOR b XOR sum.
- R3: A clock edge with rst high sets sum, cout and carry to all zeros, whatever the operand inputs are.
- R4: With TOPO set to TOPO_KS (encoding 0), the outputs satisfy R1 and R2 for every operand pair.
- R5: With TOPO set to TOPO_SK (encoding 1), the outputs satisfy R1 and R2 for every operand pair.
- R6: With TOPO set to TOPO_BK (encoding 2), the outputs satisfy R1 and R2 for every operand pair.
- R7: With RADIX set to 4, every topology gives the same outputs as with RADIX set to 2. This also holds for a WIDTH that is not a power of four, such as 8.
- R8: When every bit propagates (a XOR b all ones), cout equals cin, sum is all ones when cin is 0 and all zeros when cin is 1, and every carry bit equals cin.
- R9: When no bit generates or propagates (a and b both zero), cout is 0, sum equals cin in bit 0 and zero elsewhere, and only carry bit 0 can be set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Registered sum |
| cout | output | 1 | Registered carry out of the top bit |
| carry | output | WIDTH | Registered carry into each bit position |

## Verification
The bound checker watches, on every cycle, the arithmetic relation between the sampled operands and the registered result. It also checks the carry vector against the sum, the clearing by reset, and the all-propagate and all-kill corners.

What a property cannot show is that each topology and radix is correct. Every tree gives the same answer when it works, and the property only sees one elaborated instance at a time. That coverage comes from the bench's scenarios. The bench runs all six tree and radix pairs side by side at 8, 16 and 64 bits. It sweeps every 8-bit operand pair and carry-in, with random upper bits for the wider instances.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

  typedef enum logic [1:0] {
    TOPO_KS = 2'd0,
    TOPO_SK = 2'd1,
    TOPO_BK = 2'd2
  } topo_e;

  // Levels of a plain tree for the given radix: ceil(log_radix(width)).
  function automatic int tree_levels(int radix, int width);
    int lg;
    lg = $clog2(width);
    return (radix == 4) ? (lg + 1) / 2 : lg;
  endfunction

  // Brent-Kung builds an up-sweep followed by a down-sweep.
  function automatic int net_levels(topo_e topo, int radix, int width);
    return (topo == TOPO_BK) ? 2 * tree_levels(radix, width) : tree_levels(radix, width);
  endfunction

  // Bit position that feeds operand slot m of the node at (lvl, idx), or -1.
  // Slot 0 is the node's own (most significant) group; higher slots lie lower.
  function automatic int src_index(topo_e topo, int radix, int width,
                                   int lvl, int idx, int m);
    int nl, sh, s, blk, q, k, base, kk, j, d;
    nl = tree_levels(radix, width);
    sh = (radix == 4) ? 2 : 1;
    if (m == 0) return idx;
    case (topo)
      TOPO_KS: begin
        s = 1 << (lvl * sh);
        j = idx - m * s;
        return (j >= 0) ? j : -1;
      end
      TOPO_SK: begin
        s    = 1 << (lvl * sh);
        blk  = s * radix;
        q    = idx % blk;
        k    = q / s;
        base = idx - q;
        if (m > k) return -1;
        return base + (k - m) * s + s - 1;
      end
      default: begin
        if (lvl < nl) begin
          s = 1 << (lvl * sh);
          if ((((idx + 1) % (s * radix)) == 0) || (idx == width - 1)) begin
            j = idx - m * s;
            return (j >= 0) ? j : -1;
          end
          return -1;
        end
        d   = lvl - nl;
        s   = 1 << ((nl - 1 - d) * sh);
        blk = s * radix;
        if ((((idx + 1) % s) != 0) || (((idx + 1) % blk) == 0) || (idx == width - 1))
          return -1;
        base = (idx + 1) - ((idx + 1) % blk);
        kk   = (idx + 1 - base) / s - 1;
        if (m <= kk) return idx - m * s;
        if ((m == kk + 1) && (base > 0)) return base - 1;
        return -1;
      end
    endcase
  endfunction

  function automatic int op_count(topo_e topo, int radix, int width, int lvl, int idx);
    int n;
    n = 0;
    for (int m = 0; m < radix; m++)
      if (src_index(topo, radix, width, lvl, idx, m) >= 0) n++;
    return n;
  endfunction

endpackage

// File: rtl/pfx_pregen.sv
module pfx_pregen #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] g,
  output logic [WIDTH-1:0] p
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign g[i] = a[i] & b[i];
    assign p[i] = a[i] ^ b[i];
  end

endmodule

// File: rtl/pfx_node.sv
module pfx_node #(
  parameter int RADIX = 2
) (
  input  logic [RADIX-1:0] g_i,
  input  logic [RADIX-1:0] p_i,
  output logic             g_o,
  output logic             p_o
);

  logic gacc, pacc;

  // Fold from the lowest group (highest slot) up to the node's own group.
  always_comb begin
    gacc = g_i[RADIX-1];
    pacc = p_i[RADIX-1];
    for (int m = RADIX - 2; m >= 0; m--) begin
      gacc = g_i[m] | (p_i[m] & gacc);
      pacc = p_i[m] & pacc;
    end
  end

  assign g_o = gacc;
  assign p_o = pacc;

endmodule

// File: rtl/pfx_network.sv
module pfx_network
  import pfx_pkg::*;
#(
  parameter int    WIDTH = 16,
  parameter topo_e TOPO  = TOPO_SK,
  parameter int    RADIX = 2
) (
  input  logic [WIDTH-1:0] g_in,
  input  logic [WIDTH-1:0] p_in,
  output logic [WIDTH-1:0] grp_g,
  output logic [WIDTH-1:0] grp_p
);

  localparam int NLEV = net_levels(TOPO, RADIX, WIDTH);

  for (genvar lv = 0; lv < NLEV; lv++) begin : g_lv
    logic [WIDTH-1:0] gs, ps, go, po;

    if (lv == 0) begin : g_first
      assign gs = g_in;
      assign ps = p_in;
    end else begin : g_next
      assign gs = g_lv[lv-1].go;
      assign ps = g_lv[lv-1].po;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      localparam int NOPS = op_count(TOPO, RADIX, WIDTH, lv, i);
      if (NOPS < 2) begin : g_wire
        assign go[i] = gs[i];
        assign po[i] = ps[i];
      end else begin : g_cell
        logic [RADIX-1:0] og, op;
        for (genvar m = 0; m < RADIX; m++) begin : g_op
          localparam int SRC = src_index(TOPO, RADIX, WIDTH, lv, i, m);
          if (SRC >= 0) begin : g_use
            assign og[m] = gs[SRC];
            assign op[m] = ps[SRC];
          end else begin : g_ident
            assign og[m] = 1'b0;
            assign op[m] = 1'b1;
          end
        end
        pfx_node #(.RADIX(RADIX)) u_node (
          .g_i (og),
          .p_i (op),
          .g_o (go[i]),
          .p_o (po[i])
        );
      end
    end
  end

  assign grp_g = g_lv[NLEV-1].go;
  assign grp_p = g_lv[NLEV-1].po;

endmodule

// File: rtl/prefix_carry_adder.sv
module prefix_carry_adder
  import pfx_pkg::*;
#(
  parameter int    WIDTH = 16,
  parameter topo_e TOPO  = TOPO_SK,
  parameter int    RADIX = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic [WIDTH-1:0] carry
);

  logic [WIDTH-1:0] bit_g, bit_p, grp_g, grp_p;
  logic [WIDTH:0]   cvec;

  pfx_pregen #(.WIDTH(WIDTH)) u_pre (
    .a (a),
    .b (b),
    .g (bit_g),
    .p (bit_p)
  );

  pfx_network #(.WIDTH(WIDTH), .TOPO(TOPO), .RADIX(RADIX)) u_net (
    .g_in  (bit_g),
    .p_in  (bit_p),
    .grp_g (grp_g),
    .grp_p (grp_p)
  );

  // Carry into bit i+1 from the span [i:0] plus the incoming carry.
  assign cvec[0]       = cin;
  assign cvec[WIDTH:1] = grp_g | (grp_p & {WIDTH{cin}});

  always_ff @(posedge clk) begin
    if (rst) begin
      sum   <= '0;
      cout  <= 1'b0;
      carry <= '0;
    end else begin
      sum   <= bit_p ^ cvec[WIDTH-1:0];
      cout  <= cvec[WIDTH];
      carry <= cvec[WIDTH-1:0];
    end
  end

endmodule

// File: rtl/pfx_adder_chk.sv
module pfx_adder_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             cin,
  input logic [WIDTH-1:0] sum,
  input logic             cout,
  input logic [WIDTH-1:0] carry
);

  a_r1_sum_matches_add: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ({cout, sum} == ({1'b0, $past(a)} + {1'b0, $past(b)} + {{WIDTH{1'b0}}, $past(cin)})));

  a_r2_carry_low_is_cin: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (carry[0] == $past(cin)));

  a_r2_carry_vs_sum: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (carry == ($past(a) ^ $past(b) ^ sum)));

  a_r3_reset_clears: assert property (@(posedge clk)
    rst |=> (sum == '0) && !cout && (carry == '0));

  a_r8_all_propagate: assert property (@(posedge clk) disable iff (rst)
    (&(a ^ b)) |=> (cout == $past(cin)) && (sum == {WIDTH{~$past(cin)}})
                   && (carry == {WIDTH{$past(cin)}}));

  a_r9_all_kill: assert property (@(posedge clk) disable iff (rst)
    ((a | b) == '0) |=> !cout && (sum == {{(WIDTH-1){1'b0}}, $past(cin)})
                        && (carry[WIDTH-1:1] == '0));

endmodule

bind prefix_carry_adder pfx_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .a     (a),
  .b     (b),
  .cin   (cin),
  .sum   (sum),
  .cout  (cout),
  .carry (carry)
);

// File: tb/sim_prefix_carry_adder.sv
`timescale 1ns/1ps
module sim_prefix_carry_adder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] a_in = '0;
  logic [63:0] b_in = '0;
  logic        c_in = 1'b0;

  always #2.5 clk = ~clk;   // 200 MHz

  int checks = 0;
  int errors = 0;

  // Six configurations per width: index k -> topology k/2, radix 2 or 4 by k%2.
  logic [7:0]  s8[6],  k8[6];  logic o8[6];
  logic [15:0] s16[6], k16[6]; logic o16[6];
  logic [63:0] s64[6], k64[6]; logic o64[6];

  for (genvar k = 0; k < 6; k++) begin : g_w8
    prefix_carry_adder #(.WIDTH(8), .TOPO(pfx_pkg::topo_e'(k/2)), .RADIX((k%2 == 1) ? 4 : 2)) u0 (
      .clk(clk), .rst(rst), .a(a_in[7:0]), .b(b_in[7:0]), .cin(c_in),
      .sum(s8[k]), .cout(o8[k]), .carry(k8[k]));
  end
  for (genvar k = 0; k < 6; k++) begin : g_w16
    prefix_carry_adder #(.WIDTH(16), .TOPO(pfx_pkg::topo_e'(k/2)), .RADIX((k%2 == 1) ? 4 : 2)) u0 (
      .clk(clk), .rst(rst), .a(a_in[15:0]), .b(b_in[15:0]), .cin(c_in),
      .sum(s16[k]), .cout(o16[k]), .carry(k16[k]));
  end
  for (genvar k = 0; k < 6; k++) begin : g_w64
    prefix_carry_adder #(.WIDTH(64), .TOPO(pfx_pkg::topo_e'(k/2)), .RADIX((k%2 == 1) ? 4 : 2)) u0 (
      .clk(clk), .rst(rst), .a(a_in), .b(b_in), .cin(c_in),
      .sum(s64[k]), .cout(o64[k]), .carry(k64[k]));
  end

  typedef struct packed {
    logic [63:0] s0, s1, s2;
    logic [63:0] k0, k1, k2;
    logic        o0, o1, o2;
    logic [3:0]  note;       // 8 -> R8 corner, 9 -> R9 corner, else 0
  } exp_t;

  exp_t q[$];

  function automatic logic [64:0] add_w(int w, logic [63:0] x, logic [63:0] y, logic c);
    logic [63:0] m;
    logic [64:0] f;
    m = (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
    f = {1'b0, x & m} + {1'b0, y & m} + {64'd0, c};
    return {f[w], f[63:0] & m};
  endfunction

  function automatic logic [63:0] mask_w(int w);
    return (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
  endfunction

  function automatic string cfg_tag(int k);
    string t;
    case (k / 2)
      0:       t = "R4 kogge-stone";
      1:       t = "R5 sklansky";
      default: t = "R6 brent-kung";
    endcase
    if (k % 2 == 1) t = {t, " R7 radix-4"};
    else            t = {t, " radix-2"};
    return t;
  endfunction

  // kind: 0 sum (R1), 1 cout (R1), 2 carry vector (R2), 3 reset value (R3)
  task automatic chk(int k, int w, int kind, logic [3:0] note, logic [63:0] got, logic [63:0] exp);
    string req;
    checks++;
    if (got !== exp) begin
      errors++;
      case (kind)
        0:       req = "R1 sum";
        1:       req = "R1 cout";
        2:       req = "R2 carry";
        default: req = "R3 reset";
      endcase
      if (note == 4'd8)      req = {req, " R8 all-propagate"};
      else if (note == 4'd9) req = {req, " R9 all-kill"};
      $display("FAIL %s %s W=%0d actual=%h expected=%h", req, cfg_tag(k), w, got, exp);
    end
  endtask

  // Driver: apply operands at the falling edge and queue what must appear.
  task automatic push(logic [63:0] x, logic [63:0] y, logic c, logic [3:0] note);
    exp_t it;
    logic [64:0] r;
    @(negedge clk);
    a_in = x; b_in = y; c_in = c;
    r = add_w(8, x, y, c);  it.s0 = r[63:0]; it.o0 = r[64];
    it.k0 = (x ^ y ^ r[63:0]) & mask_w(8);
    r = add_w(16, x, y, c); it.s1 = r[63:0]; it.o1 = r[64];
    it.k1 = (x ^ y ^ r[63:0]) & mask_w(16);
    r = add_w(64, x, y, c); it.s2 = r[63:0]; it.o2 = r[64];
    it.k2 = x ^ y ^ r[63:0];
    it.note = note;
    q.push_back(it);
  endtask

  // Monitor: one register stage, so each queued item is due just after the next rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        for (int k = 0; k < 6; k++) begin
          chk(k, 8,  0, it.note, {56'd0, s8[k]},  it.s0);
          chk(k, 8,  1, it.note, {63'd0, o8[k]},  {63'd0, it.o0});
          chk(k, 8,  2, it.note, {56'd0, k8[k]},  it.k0);
          chk(k, 16, 0, it.note, {48'd0, s16[k]}, it.s1);
          chk(k, 16, 1, it.note, {63'd0, o16[k]}, {63'd0, it.o1});
          chk(k, 16, 2, it.note, {48'd0, k16[k]}, it.k1);
          chk(k, 64, 0, it.note, s64[k],          it.s2);
          chk(k, 64, 1, it.note, {63'd0, o64[k]}, {63'd0, it.o2});
          chk(k, 64, 2, it.note, k64[k],          it.k2);
        end
      end
    end
  end

  // R3: every output of every instance is zero while reset is held.
  task automatic check_reset();
    for (int k = 0; k < 6; k++) begin
      chk(k, 8,  3, 4'd0, {56'd0, s8[k]} | {63'd0, o8[k]} | {56'd0, k8[k]}, 64'd0);
      chk(k, 16, 3, 4'd0, {48'd0, s16[k]} | {63'd0, o16[k]} | {48'd0, k16[k]}, 64'd0);
      chk(k, 64, 3, 4'd0, s64[k] | {63'd0, o64[k]} | k64[k], 64'd0);
    end
  endtask

  task automatic drain();
    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] ones;
    ones = {64{1'b1}};
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check_reset();  // R3 after power-up
    @(negedge clk);
    rst = 1'b0;

    // R8: every position propagates; R9: no position generates or propagates
    push(ones, 64'd0, 1'b1, 4'd8);
    push(ones, 64'd0, 1'b0, 4'd8);
    push(64'h5555_aaaa_0f0f_f0f0, 64'haaaa_5555_f0f0_0f0f, 1'b1, 4'd8);
    push(64'd0, 64'd0, 1'b1, 4'd9);
    push(64'd0, 64'd0, 1'b0, 4'd9);
    push(ones, ones, 1'b1, 4'd0);
    push(ones, ones, 1'b0, 4'd0);
    push(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, 4'd0);

    // R1/R2/R4-R7: all 8-bit operand pairs; wider instances get random upper bits
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        for (int c = 0; c < 2; c++) begin
          logic [63:0] ra, rb;
          ra = {$urandom, $urandom};
          rb = {$urandom, $urandom};
          push({ra[63:8], x[7:0]}, {rb[63:8], y[7:0]}, c[0], 4'd0);
        end
      end
    end
    drain();

    // R3 mid-run: reset wins over live operands
    @(negedge clk);
    rst = 1'b1; a_in = ones; b_in = 64'd1; c_in = 1'b1;
    @(posedge clk);
    #1;
    check_reset();
    @(negedge clk);
    rst = 1'b0;

    for (int n = 0; n < 200; n++) push({$urandom, $urandom}, {$urandom, $urandom}, n[0], 4'd0);
    drain();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule